// File: doc/BRIEF.md
# DDR Interleaved ADC Sample Capture

This block receives samples from a 16-bit converter that sends each sample over eight source-synchronous lanes at double data rate. The converter puts the odd-numbered sample bits on the lanes for the rising edge of its data clock and the even-numbered bits on the lanes for the falling edge. The block captures both phases with behavioural rising-edge and falling-edge registers. It then weaves the two bytes back into one 16-bit word in the capture clock domain, which is the data clock itself. It emits one word per data-clock cycle with a valid strobe.

At some clock rates the two captured phases come out reversed. A runtime swap input exchanges the roles of the two phases. The swap value is taken at the rising edge that opens a sample, so a change can never split a word. An over-range flag from the converter is captured with the rising-phase byte and leaves the block together with its word. A sticky overflow flag records any cycle in which a word was offered while the downstream side was not ready. A write-one-to-clear pulse clears that flag.

Top module: `adc_ddr_capture`

## Requirements
- R1: While rst_ni is low, sample_o, valid_o, orng_o and ovf_o are all zero, whatever the lanes carry.
- R2: With swap low, lane i captured at a rising edge of clk_i becomes sample bit 2i+1, and lane i captured at the following falling edge becomes sample bit 2i.
- R3: With swap high, lane i of the rising-edge byte becomes sample bit 2i, and lane i of the falling-edge byte becomes sample bit 2i+1.
- R4: swap_i is sampled at the same rising edge as the first byte of a sample and applies to that whole sample. Toggling it on every sample never mixes orderings inside one word.
- R5: valid_o stays low until the first complete byte pair after reset has been captured, and is high on every cycle after that. A word appears on sample_o one clock cycle after the rising edge that captured its first byte, so valid_o first goes high at the second rising edge after reset release.
- R6: orng_i is sampled at the rising edge that captures a sample's first byte, and it appears on orng_o in the same cycle as that sample.
- R7: At a rising edge where valid_o is high and rdy_i is low, ovf_o is set.
- R8: ovf_o stays set until a rising edge with ovf_clr_i high. If the set condition of R7 holds at that same edge, the flag stays set.
- R9: A clear pulse while ovf_o is low and no overflow condition holds leaves ovf_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock from the converter, also the capture clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lane_i | input | 8 | DDR data lanes |
| orng_i | input | 1 | Converter over-range flag, taken with the rising byte |
| swap_i | input | 1 | Exchange the roles of the rising and falling phases |
| rdy_i | input | 1 | Downstream ready |
| ovf_clr_i | input | 1 | Write-one pulse that clears the overflow flag |
| sample_o | output | 16 | Reassembled sample |
| valid_o | output | 1 | Sample valid strobe |
| orng_o | output | 1 | Over-range flag aligned with sample_o |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The overflow set condition and the software clear can land on the same rising edge. The bench provokes this by holding rdy_i low in the very cycle that ovf_clr_i is pulsed, both directed and through random ready and clear draws. It judges the result against a bench-side flag model in which setting has priority. Swap changes on every sample boundary are mixed with random lane bytes, so a word assembled with half of each ordering would show up as a mismatch against the reference weave.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  parameter int unsigned DEF_LANES = 8;

  typedef enum logic {
    ORD_NORMAL  = 1'b0,
    ORD_SWAPPED = 1'b1
  } byte_order_e;
endpackage

// File: rtl/ddr_phase_capture.sv
module ddr_phase_capture #(
  parameter int unsigned LANES  = adc_cap_pkg::DEF_LANES,
  parameter int unsigned SIDE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  lane_i,
  input  logic [SIDE_W-1:0] side_i,
  output logic [LANES-1:0]  rise_o,
  output logic [LANES-1:0]  fall_o,
  output logic [SIDE_W-1:0] side_o,
  output logic              seen_o
);
  logic [LANES-1:0] rise_q, fall_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rise_q[g] <= 1'b0;
      else         rise_q[g] <= lane_i[g];
    end
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fall_q[g] <= 1'b0;
      else         fall_q[g] <= lane_i[g];
    end
  end

  // side-band bits travel with the rising byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      side_o <= '0;
      seen_o <= 1'b0;
    end else begin
      side_o <= side_i;
      seen_o <= 1'b1;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/sample_weave.sv
module sample_weave #(
  parameter int unsigned LANES = adc_cap_pkg::DEF_LANES,
  localparam int unsigned SW   = 2 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LANES-1:0] rise_i,
  input  logic [LANES-1:0] fall_i,
  input  adc_cap_pkg::byte_order_e order_i,
  input  logic             orng_i,
  output logic [SW-1:0]    sample_o,
  output logic             valid_o,
  output logic             orng_o
);
  import adc_cap_pkg::*;

  logic [LANES-1:0] odd_src, even_src;
  logic [SW-1:0]    woven;

  assign odd_src  = (order_i == ORD_SWAPPED) ? fall_i : rise_i;
  assign even_src = (order_i == ORD_SWAPPED) ? rise_i : fall_i;

  for (genvar g = 0; g < LANES; g++) begin : g_bit
    assign woven[2*g+1] = odd_src[g];
    assign woven[2*g]   = even_src[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
      orng_o   <= 1'b0;
    end else if (load_i) begin
      sample_o <= woven;
      valid_o  <= 1'b1;
      orng_o   <= orng_i;
    end
  end

  a_r5_valid_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/ovf_status.sv
module ovf_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic rdy_i,
  input  logic clr_i,
  output logic ovf_o
);
  logic hit;
  assign hit = valid_i && !rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_o <= 1'b0;
    else if (hit)   ovf_o <= 1'b1;
    else if (clr_i) ovf_o <= 1'b0;
  end

  a_r7_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rdy_i) |=> ovf_o);
  a_r8_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
  a_r8_ovf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && clr_i && rdy_i) |=> !ovf_o);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !(valid_i && !rdy_i)) |=> !ovf_o);
endmodule

// File: rtl/adc_ddr_capture.sv
module adc_ddr_capture #(
  parameter int unsigned LANES = adc_cap_pkg::DEF_LANES,
  localparam int unsigned SW   = 2 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_i,
  input  logic             orng_i,
  input  logic             swap_i,
  input  logic             rdy_i,
  input  logic             ovf_clr_i,
  output logic [SW-1:0]    sample_o,
  output logic             valid_o,
  output logic             orng_o,
  output logic             ovf_o
);
  import adc_cap_pkg::*;

  logic [LANES-1:0] rise_b, fall_b;
  logic [1:0]       side_b;
  logic             seen_b;
  byte_order_e      order_b;

  ddr_phase_capture #(.LANES(LANES), .SIDE_W(2)) i_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lane_i (lane_i),
    .side_i ({swap_i, orng_i}),
    .rise_o (rise_b),
    .fall_o (fall_b),
    .side_o (side_b),
    .seen_o (seen_b)
  );

  assign order_b = side_b[1] ? ORD_SWAPPED : ORD_NORMAL;

  sample_weave #(.LANES(LANES)) i_weave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (seen_b),
    .rise_i   (rise_b),
    .fall_i   (fall_b),
    .order_i  (order_b),
    .orng_i   (side_b[0]),
    .sample_o (sample_o),
    .valid_o  (valid_o),
    .orng_o   (orng_o)
  );

  ovf_status i_ovf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_o),
    .rdy_i   (rdy_i),
    .clr_i   (ovf_clr_i),
    .ovf_o   (ovf_o)
  );

  logic [LANES-1:0] odd_w, even_w;
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      odd_w[i]  = sample_o[2*i+1];
      even_w[i] = sample_o[2*i];
    end
  end

  a_r2_odd_from_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(swap_i, 2)) |-> (odd_w == $past(lane_i, 2)));
  a_r3_even_from_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(swap_i, 2)) |-> (even_w == $past(lane_i, 2)));
  a_r6_orng_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (orng_o == $past(orng_i, 2)));
endmodule

// File: tb/test_adc_ddr_capture.sv
module test_adc_ddr_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lane = '0;
  logic        orng = 1'b0, swap = 1'b0, rdy = 1'b1, clr = 1'b0;
  logic [15:0] sample;
  logic        valid, orng_out, ovf;

  int checks = 0, errors = 0, k = 1;
  logic exp_ovf = 1'b0;
  logic [16:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ddr_capture i_adc_ddr_capture (
    .clk_i(clk), .rst_ni(rst_n), .lane_i(lane), .orng_i(orng),
    .swap_i(swap), .rdy_i(rdy), .ovf_clr_i(clr),
    .sample_o(sample), .valid_o(valid), .orng_o(orng_out), .ovf_o(ovf)
  );

  function automatic logic [15:0] weave(logic [7:0] r, logic [7:0] f, logic s);
    logic [15:0] w;
    for (int i = 0; i < 8; i++) begin
      w[2*i+1] = s ? f[i] : r[i];
      w[2*i]   = s ? r[i] : f[i];
    end
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (pair %0d)", req, act, exp, k);
    end
  endtask

  task automatic send_pair(logic [7:0] r, logic [7:0] f, logic o, logic s,
                           logic rd, logic cl, string req);
    logic [16:0] e;
    @(negedge clk); #2;
    lane = r; orng = o; swap = s; rdy = rd; clr = cl;
    if ((k >= 3) && !rd) exp_ovf = 1'b1;
    else if (cl)         exp_ovf = 1'b0;
    @(posedge clk); #2;
    lane = f;
    chk("R5 valid", {31'd0, valid}, {31'd0, (k >= 2)});
    if (k >= 2) begin
      e = expq.pop_front();
      chk(req, {16'd0, sample}, {16'd0, e[15:0]});
      chk("R6 orng", {31'd0, orng_out}, {31'd0, e[16]});
    end
    chk("R7 R8 R9 ovf", {31'd0, ovf}, {31'd0, exp_ovf});
    expq.push_back({o, weave(r, f, s)});
    k++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: outputs stay zero during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2;
      lane = 8'($urandom); orng = 1'b1; swap = i[0];
      @(posedge clk); #2;
      lane = 8'($urandom);
      chk("R1 sample", {16'd0, sample}, 32'd0);
      chk("R1 flags", {29'd0, valid, orng_out, ovf}, 32'd0);
    end
    rst_n = 1'b1;

    // directed corners, normal order (R2)
    send_pair(8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R2 sample");
    send_pair(8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, "R2 sample");
    send_pair(8'h01, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0, "R2 sample");
    for (int i = 0; i < 40; i++)
      send_pair(8'($urandom), 8'($urandom), 1'($urandom), 1'b0, 1'b1, 1'b0, "R2 sample");
    // swapped order (R3)
    send_pair(8'hFF, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R3 sample");
    send_pair(8'h80, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0, "R3 sample");
    for (int i = 0; i < 40; i++)
      send_pair(8'($urandom), 8'($urandom), 1'($urandom), 1'b1, 1'b1, 1'b0, "R3 sample");
    // swap toggling on every boundary (R4)
    for (int i = 0; i < 40; i++)
      send_pair(8'($urandom), 8'($urandom), 1'($urandom), i[0], 1'b1, 1'b0, "R4 sample");
    // R9: clear with nothing set
    send_pair(8'h5A, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, "R9 sample");
    chk("R9 ovf low", {31'd0, ovf}, 32'd0);
    // R7: not ready once sets the flag
    send_pair(8'h3C, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, "R7 sample");
    chk("R7 ovf set", {31'd0, ovf}, 32'd1);
    for (int i = 0; i < 3; i++)
      send_pair(8'($urandom), 8'($urandom), 1'b0, 1'b0, 1'b1, 1'b0, "R8 sample");
    chk("R8 ovf held", {31'd0, ovf}, 32'd1);
    // R8: clear and set on the same edge, set wins
    send_pair(8'h11, 8'h22, 1'b1, 1'b0, 1'b0, 1'b1, "R8 sample");
    chk("R8 set wins", {31'd0, ovf}, 32'd1);
    send_pair(8'h33, 8'h44, 1'b0, 1'b1, 1'b1, 1'b1, "R8 sample");
    chk("R8 cleared", {31'd0, ovf}, 32'd0);
    // mixed random traffic
    for (int i = 0; i < 300; i++)
      send_pair(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 8) != 0, ($urandom % 6) == 0, "R4 mixed sample");
    send_pair(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R2 sample");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule